// File: doc/BRIEF.md
# Transmit Queue Request and Abort Controller

This block holds the control state for a single transmit queue of a message-bus controller. Software sets a send-request bit to ask the bus engine to send what is queued, and the bit drops by itself once the last queued message has gone out. If software writes the bit to 0 while it is still set, the block treats that write as an abort command. It then raises an abort request toward the bus engine and holds it until the engine acknowledges.

The block also keeps three status flags for the message in flight: aborted, lost arbitration and bus error. It can re-arm the send request on its own when a remote request frame arrives and that feature is enabled. It passes a registered 2-bit priority to an external arbiter that chooses between queues. A FIFO reset pulse returns the request, the abort and the flags to 0.

All outputs are registered. Each takes its new value on the clock edge after the input that causes it.

Top module: `txq_ctrl`

## Requirements
- R1: In transmit mode, with no abort pending, a software write with value 1 sets `req` on the next clock edge.
- R2: When `req` is 1, no write is present and no abort is pending, an `eng_sent` pulse together with `q_empty`=1 clears `req`. An `eng_sent` pulse with `q_empty`=0 leaves `req` at 1.
- R3: A software write with value 0 while `req`=1 clears `req` and sets `abort_req` on the next edge. A write with value 0 while `req`=0 changes nothing.
- R4: `abort_req` stays 1 until an `eng_aborted` or `eng_sent` pulse arrives, and then drops to 0. While it is 1, `req` stays 0 and software writes and remote frames are ignored.
- R5: `stat_aborted` becomes 1 after an `eng_aborted` pulse and 0 after an `eng_sent` pulse. If both pulses arrive in the same cycle, the value 1 wins.
- R6: `stat_lost_arb` and `stat_bus_err` are set by `eng_lost_arb` and `eng_bus_err` respectively. A software write that raises `req` from 0 to 1 clears them, but a set pulse in the same cycle takes precedence.
- R7: With `cfg_auto_rtr`=1, an `eng_rtr_rx` pulse sets `req` when no write, drain or abort applies in that cycle. With `cfg_auto_rtr`=0 the pulse has no effect on `req`.
- R8: `arb_prio` is `cfg_prio` registered by one cycle. The encoding is 3 for highest, 2 for high intermediate, 1 for low intermediate and 0 for lowest.
- R9: In receive mode (`cfg_tx_mode`=0), `req` and `abort_req` are held at 0 and software writes and remote frames have no effect.
- R10: A `fifo_reset` pulse clears `req`, `abort_req` and all three flags on the next edge, and overrides every other input. `rst` clears every output, including `arb_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_mode | input | 1 | 1 = queue is a transmit queue, 0 = receive |
| cfg_auto_rtr | input | 1 | Enable re-arm of the request on a remote frame |
| cfg_prio | input | 2 | Queue priority setting |
| sw_req_wr | input | 1 | Software write strobe for the request bit |
| sw_req_val | input | 1 | Value written to the request bit |
| eng_sent | input | 1 | Pulse: a message completed successfully |
| eng_lost_arb | input | 1 | Pulse: the message lost arbitration |
| eng_bus_err | input | 1 | Pulse: a bus error hit the message |
| eng_aborted | input | 1 | Pulse: the message was aborted |
| eng_rtr_rx | input | 1 | Pulse: a remote request frame was received |
| q_empty | input | 1 | No further message queued after the current one |
| fifo_reset | input | 1 | Queue reset pulse |
| req | output | 1 | Send-request bit |
| abort_req | output | 1 | Abort request held toward the bus engine |
| stat_aborted | output | 1 | Last message was aborted |
| stat_lost_arb | output | 1 | Message lost arbitration |
| stat_bus_err | output | 1 | Bus error while sending |
| arb_prio | output | 2 | Priority passed to the queue arbiter |

## Verification
Errors in the request state machine appear on `req` or `abort_req` one edge after the stimulus that exposes them. Examples are an abort that never clears, a drain taken while messages remain queued, or a remote frame acted on while an abort is pending. A stuck flag appears on the status outputs at the next completion or reset, and a dropped priority appears on `arb_prio` one cycle later. Because every output is compared with a cycle-accurate model on every cycle, a wrong state is reported within one clock of when it first becomes visible.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int PRIO_W = 2;

  typedef struct packed {
    logic aborted;
    logic lost_arb;
    logic bus_err;
  } txq_flags_t;
endpackage

// File: rtl/txq_req_fsm.sv
module txq_req_fsm (
  input  logic clk,
  input  logic rst,
  input  logic tx_mode,
  input  logic auto_rtr,
  input  logic wr,
  input  logic wr_val,
  input  logic sent,
  input  logic aborted_ack,
  input  logic rtr_rx,
  input  logic q_empty,
  input  logic fifo_reset,
  output logic req_q,
  output logic abort_q,
  output logic raise_evt
);
  logic req_d, abort_d;

  always_comb begin
    req_d     = req_q;
    abort_d   = abort_q;
    raise_evt = 1'b0;
    if (fifo_reset || !tx_mode) begin
      req_d   = 1'b0;
      abort_d = 1'b0;
    end else if (abort_q) begin
      req_d = 1'b0;
      if (sent || aborted_ack) abort_d = 1'b0;
    end else if (wr) begin
      if (wr_val) begin
        req_d     = 1'b1;
        raise_evt = !req_q;
      end else if (req_q) begin
        req_d   = 1'b0;
        abort_d = 1'b1;
      end
    end else if (req_q && sent && q_empty) begin
      req_d = 1'b0;
    end else if (auto_rtr && rtr_rx) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/txq_status.sv
module txq_status
  import txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_reset,
  input  logic       sent,
  input  logic       aborted_ack,
  input  logic       lost_arb,
  input  logic       bus_err,
  input  logic       raise_evt,
  output txq_flags_t flags_q
);
  txq_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (fifo_reset) begin
      flags_d = '0;
    end else begin
      if (aborted_ack)   flags_d.aborted = 1'b1;
      else if (sent)     flags_d.aborted = 1'b0;
      if (lost_arb)      flags_d.lost_arb = 1'b1;
      else if (raise_evt) flags_d.lost_arb = 1'b0;
      if (bus_err)       flags_d.bus_err = 1'b1;
      else if (raise_evt) flags_d.bus_err = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/txq_prio_reg.sv
module txq_prio_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] prio_in,
  output logic [W-1:0] prio_q
);
  always_ff @(posedge clk) begin
    if (rst) prio_q <= '0;
    else     prio_q <= prio_in;
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int PW = PRIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_tx_mode,
  input  logic          cfg_auto_rtr,
  input  logic [PW-1:0] cfg_prio,
  input  logic          sw_req_wr,
  input  logic          sw_req_val,
  input  logic          eng_sent,
  input  logic          eng_lost_arb,
  input  logic          eng_bus_err,
  input  logic          eng_aborted,
  input  logic          eng_rtr_rx,
  input  logic          q_empty,
  input  logic          fifo_reset,
  output logic          req,
  output logic          abort_req,
  output logic          stat_aborted,
  output logic          stat_lost_arb,
  output logic          stat_bus_err,
  output logic [PW-1:0] arb_prio
);
  logic       raise_evt;
  txq_flags_t flags;

  txq_req_fsm u_fsm (
    .clk(clk), .rst(rst), .tx_mode(cfg_tx_mode), .auto_rtr(cfg_auto_rtr),
    .wr(sw_req_wr), .wr_val(sw_req_val), .sent(eng_sent),
    .aborted_ack(eng_aborted), .rtr_rx(eng_rtr_rx), .q_empty(q_empty),
    .fifo_reset(fifo_reset), .req_q(req), .abort_q(abort_req),
    .raise_evt(raise_evt)
  );

  txq_status u_stat (
    .clk(clk), .rst(rst), .fifo_reset(fifo_reset), .sent(eng_sent),
    .aborted_ack(eng_aborted), .lost_arb(eng_lost_arb), .bus_err(eng_bus_err),
    .raise_evt(raise_evt), .flags_q(flags)
  );

  txq_prio_reg #(.W(PW)) u_prio (
    .clk(clk), .rst(rst), .prio_in(cfg_prio), .prio_q(arb_prio)
  );

  assign stat_aborted  = flags.aborted;
  assign stat_lost_arb = flags.lost_arb;
  assign stat_bus_err  = flags.bus_err;
endmodule

// File: rtl/txq_ctrl_chk.sv
module txq_ctrl_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_tx_mode,
  input logic          cfg_auto_rtr,
  input logic [PW-1:0] cfg_prio,
  input logic          sw_req_wr,
  input logic          sw_req_val,
  input logic          eng_sent,
  input logic          eng_aborted,
  input logic          eng_rtr_rx,
  input logic          q_empty,
  input logic          fifo_reset,
  input logic          req,
  input logic          abort_req,
  input logic          stat_aborted,
  input logic          stat_lost_arb,
  input logic          stat_bus_err,
  input logic [PW-1:0] arb_prio
);
  a_r3_clear_is_abort: assert property (@(posedge clk) disable iff (rst)
    (cfg_tx_mode && !fifo_reset && !abort_req && req && sw_req_wr && !sw_req_val)
    |=> (abort_req && !req));

  a_r4_abort_held: assert property (@(posedge clk) disable iff (rst)
    (cfg_tx_mode && !fifo_reset && abort_req && !eng_sent && !eng_aborted)
    |=> abort_req);

  a_r4_no_req_with_abort: assert property (@(posedge clk) disable iff (rst)
    !(abort_req && req));

  a_r2_drain: assert property (@(posedge clk) disable iff (rst)
    (cfg_tx_mode && !fifo_reset && !abort_req && req && !sw_req_wr && eng_sent && q_empty)
    |=> !req);

  a_r9_rx_idle: assert property (@(posedge clk) disable iff (rst)
    !cfg_tx_mode |=> (!req && !abort_req));

  a_r10_fifo_reset: assert property (@(posedge clk) disable iff (rst)
    fifo_reset |=> (!req && !abort_req && !stat_aborted && !stat_lost_arb && !stat_bus_err));

  a_r5_abort_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_aborted && !fifo_reset) |=> stat_aborted);

  a_r8_prio_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (arb_prio == $past(cfg_prio)));

  logic unused_ok;
  assign unused_ok = cfg_auto_rtr ^ eng_rtr_rx;
endmodule

bind txq_ctrl txq_ctrl_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cfg_tx_mode(cfg_tx_mode), .cfg_auto_rtr(cfg_auto_rtr),
  .cfg_prio(cfg_prio), .sw_req_wr(sw_req_wr), .sw_req_val(sw_req_val),
  .eng_sent(eng_sent), .eng_aborted(eng_aborted), .eng_rtr_rx(eng_rtr_rx),
  .q_empty(q_empty), .fifo_reset(fifo_reset), .req(req), .abort_req(abort_req),
  .stat_aborted(stat_aborted), .stat_lost_arb(stat_lost_arb),
  .stat_bus_err(stat_bus_err), .arb_prio(arb_prio)
);

// File: tb/txq_ctrl_test.sv
`timescale 1ns/1ps
module txq_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tx_mode = 1'b0, cfg_auto_rtr = 1'b0;
  logic [1:0] cfg_prio = 2'd0;
  logic sw_req_wr = 0, sw_req_val = 0, eng_sent = 0, eng_lost_arb = 0;
  logic eng_bus_err = 0, eng_aborted = 0, eng_rtr_rx = 0, q_empty = 0, fifo_reset = 0;
  logic req, abort_req, stat_aborted, stat_lost_arb, stat_bus_err;
  logic [1:0] arb_prio;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_req, m_abt, m_fa, m_fl, m_fe;
  logic [1:0] m_prio;

  always #2 clk = ~clk;

  txq_ctrl uut (
    .clk(clk), .rst(rst), .cfg_tx_mode(cfg_tx_mode), .cfg_auto_rtr(cfg_auto_rtr),
    .cfg_prio(cfg_prio), .sw_req_wr(sw_req_wr), .sw_req_val(sw_req_val),
    .eng_sent(eng_sent), .eng_lost_arb(eng_lost_arb), .eng_bus_err(eng_bus_err),
    .eng_aborted(eng_aborted), .eng_rtr_rx(eng_rtr_rx), .q_empty(q_empty),
    .fifo_reset(fifo_reset), .req(req), .abort_req(abort_req),
    .stat_aborted(stat_aborted), .stat_lost_arb(stat_lost_arb),
    .stat_bus_err(stat_bus_err), .arb_prio(arb_prio)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Model next state from the requirement list
  task automatic model_step();
    logic raise;
    raise = 1'b0;
    if (fifo_reset || !cfg_tx_mode) begin          // R9, R10
      m_req = 0; m_abt = 0;
    end else if (m_abt) begin                      // R4
      m_req = 0;
      if (eng_sent || eng_aborted) m_abt = 0;
    end else if (sw_req_wr) begin
      if (sw_req_val) begin raise = !m_req; m_req = 1; end   // R1
      else if (m_req) begin m_req = 0; m_abt = 1; end        // R3
    end else if (m_req && eng_sent && q_empty) m_req = 0;    // R2
    else if (cfg_auto_rtr && eng_rtr_rx) m_req = 1;          // R7
    if (fifo_reset) begin m_fa = 0; m_fl = 0; m_fe = 0; end
    else begin
      if (eng_aborted) m_fa = 1; else if (eng_sent) m_fa = 0;   // R5
      if (eng_lost_arb) m_fl = 1; else if (raise) m_fl = 0;     // R6
      if (eng_bus_err)  m_fe = 1; else if (raise) m_fe = 0;
    end
    m_prio = cfg_prio;                                          // R8
  endtask

  task automatic compare_all();
    chk("R1 R2 R3 R7 R9 req", {1'b0, req}, {1'b0, m_req});
    chk("R4 abort_req", {1'b0, abort_req}, {1'b0, m_abt});
    chk("R5 stat_aborted", {1'b0, stat_aborted}, {1'b0, m_fa});
    chk("R6 stat_lost_arb", {1'b0, stat_lost_arb}, {1'b0, m_fl});
    chk("R6 stat_bus_err", {1'b0, stat_bus_err}, {1'b0, m_fe});
    chk("R8 arb_prio", arb_prio, m_prio);
  endtask

  task automatic clear_in();
    sw_req_wr = 0; sw_req_val = 0; eng_sent = 0; eng_lost_arb = 0;
    eng_bus_err = 0; eng_aborted = 0; eng_rtr_rx = 0; fifo_reset = 0;
  endtask

  // Inputs are driven at the falling edge; the model advances, then
  // outputs are compared 1 ns after the rising edge.
  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
    @(negedge clk);
    clear_in();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #0;
    // R10 reset state
    m_req = 0; m_abt = 0; m_fa = 0; m_fl = 0; m_fe = 0; m_prio = 0;
    compare_all();

    cfg_tx_mode = 1; cfg_prio = 2'd3;
    // R1 set request
    sw_req_wr = 1; sw_req_val = 1; cycle();
    // R2 sent with queue not empty keeps, then drain
    eng_sent = 1; q_empty = 0; cycle();
    eng_sent = 1; q_empty = 1; cycle();
    // R3 write 0 while clear: no effect
    sw_req_wr = 1; sw_req_val = 0; cycle();
    // R3 abort command, R4 hold with ignored write and remote frame
    sw_req_wr = 1; sw_req_val = 1; eng_lost_arb = 1; cycle();
    sw_req_wr = 1; sw_req_val = 0; cycle();
    cfg_auto_rtr = 1; sw_req_wr = 1; sw_req_val = 1; eng_rtr_rx = 1; cycle();
    cycle();
    eng_aborted = 1; cycle();                // R4 release, R5 flag
    // R7 remote frame re-arms
    eng_rtr_rx = 1; cycle();
    cfg_auto_rtr = 0; eng_sent = 1; q_empty = 1; cycle();
    eng_rtr_rx = 1; cycle();                 // R7 disabled: no effect
    // R9 receive mode ignores writes
    cfg_tx_mode = 0; sw_req_wr = 1; sw_req_val = 1; cycle();
    cfg_tx_mode = 1; sw_req_wr = 1; sw_req_val = 1; eng_bus_err = 1; cycle();
    // R10 fifo reset overrides
    fifo_reset = 1; sw_req_wr = 1; sw_req_val = 1; eng_aborted = 1; cycle();

    for (int i = 0; i < 3000; i++) begin
      cfg_tx_mode  = ($urandom_range(0, 15) != 0);
      cfg_auto_rtr = $urandom_range(0, 1);
      cfg_prio     = 2'($urandom_range(0, 3));
      sw_req_wr    = ($urandom_range(0, 3) == 0);
      sw_req_val   = $urandom_range(0, 1);
      eng_sent     = ($urandom_range(0, 3) == 0);
      eng_lost_arb = ($urandom_range(0, 7) == 0);
      eng_bus_err  = ($urandom_range(0, 7) == 0);
      eng_aborted  = ($urandom_range(0, 5) == 0);
      eng_rtr_rx   = ($urandom_range(0, 5) == 0);
      q_empty      = $urandom_range(0, 1);
      fifo_reset   = ($urandom_range(0, 31) == 0);
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule